// File: doc/BRIEF.md
# Near Branch Target Unit

This unit forms the next instruction pointer for a near branch that stays inside the current code segment. A request carries four things: the address of the instruction that follows the branch, the operand size, a flag that says whether the core runs in 64-bit long mode, and the code segment limit. It also carries the branch operand. That operand is either a signed immediate displacement, tagged with its size, or an absolute target read from a register or from memory.

For a relative branch the unit widens the displacement by sign extension and adds it to the following-instruction address. For an absolute branch it takes the operand as it stands. It then cuts the result to the operand size and tests it. Outside long mode the test is the code segment limit. Inside long mode the test is canonical form.

One cycle after the request, exactly one of two things happens. The unit loads the new pointer and pulses an update strobe, or it keeps the old pointer and pulses a fault strobe with a code. The code separates a protection fault from a form that is not allowed in the current mode.

Top module: `jump_target_unit`

## Requirements
- R1: During and straight after reset, `ip` equals the parameter `RESET_IP` (default 0), and `ipUpdate`, `faultStrobe` and `faultCode` are all 0.
- R2: A request sampled with `reqValid` high gives exactly one one-cycle pulse on the next cycle, on either `ipUpdate` or `faultStrobe`. A cycle without a request gives no pulse on either. `faultCode` reads 0 whenever `faultStrobe` is low.
- R3: For a relative branch (`isRelative`=1), the target is `nextIp` plus the sign-extended low part of `disp`. The width of that part is set by `dispSize`: 0 selects 8 bits, 1 selects 16 bits, 2 selects 32 bits. The code 3 is reserved.
- R4: For an absolute branch (`isRelative`=0), the target is `absTarget` with no addition, and `dispSize` has no effect.
- R5: `opSize` encodes 0 as 16 bits, 1 as 32 bits and 2 as 64 bits. A 16-bit size clears every pointer bit above bit 15. A 32-bit size clears every bit above bit 31, so the sum wraps modulo 2^32.
- R6: Outside long mode, a truncated target greater than `csLimit` is refused with `faultCode` 1 (protection fault). A target equal to the limit is accepted.
- R7: In long mode, the segment limit is ignored. A target whose bits 63 down to 47 are not all equal is refused with `faultCode` 1.
- R8: The following forms are refused with `faultCode` 2 (invalid form), and this code takes precedence over code 1:
  - in long mode, any `opSize` other than 2;
  - in long mode, a relative branch with `dispSize` 1;
  - outside long mode, `opSize` 2 or 3;
  - in any mode, a relative branch with `dispSize` 3.
- R9: A refused request leaves `ip` unchanged. `ip` changes only in a cycle where `ipUpdate` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A branch request is present this cycle |
| nextIp | input | 64 | Address of the instruction after the branch |
| isRelative | input | 1 | 1: relative displacement, 0: absolute target |
| dispSize | input | 2 | Displacement width: 0 = 8, 1 = 16, 2 = 32 bits |
| disp | input | 32 | Immediate displacement, right-aligned |
| absTarget | input | 64 | Absolute target from register or memory |
| opSize | input | 2 | Operand size: 0 = 16, 1 = 32, 2 = 64 |
| longMode | input | 1 | Core runs in 64-bit long mode |
| csLimit | input | 32 | Code segment limit, inclusive |
| ip | output | 64 | Current instruction pointer |
| ipUpdate | output | 1 | One-cycle pulse when `ip` took a new target |
| faultStrobe | output | 1 | One-cycle pulse when a request was refused |
| faultCode | output | 2 | 1 = protection fault, 2 = invalid form, 0 otherwise |

## Verification
The assertions check the following on every cycle:
- each request produces exactly one outcome pulse;
- the pointer moves only together with the update strobe;
- an accepted 16-bit target has no upper bits set;
- an accepted long-mode target is canonical;
- an accepted legacy target lies within the limit;
- a long-mode request with a narrow operand size always raises the invalid-form code.

Only the directed scenarios show that the loaded value is the correct sum. They cover the sign extension of each displacement width, wrap-around at 16 and 32 bits, the target that sits exactly on the limit, and the precedence of the invalid-form code over the protection fault.

// File: rtl/jtu_pkg.sv
package jtu_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_UD   = 2'd2
  } fault_e;

  localparam logic [1:0] SZ_8  = 2'd0;
  localparam logic [1:0] SZ_16 = 2'd1;
  localparam logic [1:0] SZ_32 = 2'd2;

  localparam logic [1:0] OP_16 = 2'd0;
  localparam logic [1:0] OP_32 = 2'd1;
  localparam logic [1:0] OP_64 = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic   loadIp;
    logic   raise;
    fault_e code;
  } ctl_s;

endpackage

// File: rtl/jtu_datapath.sv
module jtu_datapath
  import jtu_pkg::*;
#(
  parameter int          IP_W     = 64,
  parameter int          DISP_W   = 32,
  parameter logic [63:0] RESET_IP = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IP_W-1:0]   nextIp,
  input  logic              isRelative,
  input  logic [1:0]        dispSize,
  input  logic [DISP_W-1:0] disp,
  input  logic [IP_W-1:0]   absTarget,
  input  logic [1:0]        opSize,
  input  ctl_s              ctl,
  output logic [IP_W-1:0]   candidate,
  output logic [IP_W-1:0]   ip,
  output logic              ipUpdate
);

  localparam int EXT8  = IP_W - 8;
  localparam int EXT16 = IP_W - 16;
  localparam int EXT32 = IP_W - 32;

  logic [IP_W-1:0] dispExt;
  logic [IP_W-1:0] rawTarget;

  // Sign extension of the selected displacement width
  always_comb begin
    unique case (dispSize)
      SZ_8:    dispExt = {{EXT8{disp[7]}}, disp[7:0]};
      SZ_16:   dispExt = {{EXT16{disp[15]}}, disp[15:0]};
      default: dispExt = {{EXT32{disp[31]}}, disp[31:0]};
    endcase
  end

  assign rawTarget = isRelative ? (nextIp + dispExt) : absTarget;

  // Truncation to the operand size
  always_comb begin
    unique case (opSize)
      OP_16:   candidate = {{EXT16{1'b0}}, rawTarget[15:0]};
      OP_32:   candidate = {{EXT32{1'b0}}, rawTarget[31:0]};
      default: candidate = rawTarget;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ip       <= RESET_IP[IP_W-1:0];
      ipUpdate <= 1'b0;
    end else begin
      ipUpdate <= ctl.loadIp;
      if (ctl.loadIp) ip <= candidate;
    end
  end

endmodule

// File: rtl/jtu_control.sv
module jtu_control
  import jtu_pkg::*;
#(
  parameter int IP_W    = 64,
  parameter int VA_BITS = 48,
  parameter int LIM_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             isRelative,
  input  logic [1:0]       dispSize,
  input  logic [1:0]       opSize,
  input  logic             longMode,
  input  logic [LIM_W-1:0] csLimit,
  input  logic [IP_W-1:0]  candidate,
  output ctl_s             ctl,
  output logic             faultStrobe,
  output fault_e           faultCode
);

  localparam int HI_W = IP_W - VA_BITS + 1;

  logic [HI_W-1:0] hiBits;
  logic            canonical;
  logic            overLimit;
  logic            badForm;
  logic            protFault;

  assign hiBits    = candidate[IP_W-1:VA_BITS-1];
  assign canonical = (&hiBits) || (~|hiBits);
  assign overLimit = candidate > {{(IP_W-LIM_W){1'b0}}, csLimit};

  always_comb begin
    badForm = isRelative && (dispSize == 2'd3);
    if (longMode) begin
      if (opSize != OP_64)                   badForm = 1'b1;
      if (isRelative && (dispSize == SZ_16)) badForm = 1'b1;
    end else begin
      if (opSize[1])                         badForm = 1'b1;
    end
  end

  assign protFault = longMode ? !canonical : overLimit;

  always_comb begin
    ctl.loadIp = reqValid && !badForm && !protFault;
    ctl.raise  = reqValid && (badForm || protFault);
    ctl.code   = badForm ? FLT_UD : (protFault ? FLT_GP : FLT_NONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultStrobe <= 1'b0;
      faultCode   <= FLT_NONE;
    end else begin
      faultStrobe <= ctl.raise;
      faultCode   <= ctl.raise ? ctl.code : FLT_NONE;
    end
  end

endmodule

// File: rtl/jump_target_unit.sv
module jump_target_unit
  import jtu_pkg::*;
#(
  parameter int          IP_W     = 64,
  parameter int          VA_BITS  = 48,
  parameter int          LIM_W    = 32,
  parameter int          DISP_W   = 32,
  parameter logic [63:0] RESET_IP = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [IP_W-1:0]   nextIp,
  input  logic              isRelative,
  input  logic [1:0]        dispSize,
  input  logic [DISP_W-1:0] disp,
  input  logic [IP_W-1:0]   absTarget,
  input  logic [1:0]        opSize,
  input  logic              longMode,
  input  logic [LIM_W-1:0]  csLimit,
  output logic [IP_W-1:0]   ip,
  output logic              ipUpdate,
  output logic              faultStrobe,
  output logic [1:0]        faultCode
);

  ctl_s            ctl;
  logic [IP_W-1:0] candidate;
  fault_e          faultCodeE;

  jtu_datapath #(
    .IP_W    (IP_W),
    .DISP_W  (DISP_W),
    .RESET_IP(RESET_IP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .nextIp    (nextIp),
    .isRelative(isRelative),
    .dispSize  (dispSize),
    .disp      (disp),
    .absTarget (absTarget),
    .opSize    (opSize),
    .ctl       (ctl),
    .candidate (candidate),
    .ip        (ip),
    .ipUpdate  (ipUpdate)
  );

  jtu_control #(
    .IP_W   (IP_W),
    .VA_BITS(VA_BITS),
    .LIM_W  (LIM_W)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .isRelative (isRelative),
    .dispSize   (dispSize),
    .opSize     (opSize),
    .longMode   (longMode),
    .csLimit    (csLimit),
    .candidate  (candidate),
    .ctl        (ctl),
    .faultStrobe(faultStrobe),
    .faultCode  (faultCodeE)
  );

  assign faultCode = faultCodeE;

endmodule

// File: rtl/jtu_chk.sv
module jtu_chk #(
  parameter int IP_W    = 64,
  parameter int VA_BITS = 48,
  parameter int LIM_W   = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [1:0]       opSize,
  input logic             longMode,
  input logic [LIM_W-1:0] csLimit,
  input logic [IP_W-1:0]  ip,
  input logic             ipUpdate,
  input logic             faultStrobe,
  input logic [1:0]       faultCode
);

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid) |-> (ipUpdate ^ faultStrobe));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !$past(reqValid) |-> (!ipUpdate && !faultStrobe));

  a_r2_code_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !faultStrobe |-> (faultCode == 2'd0));

  a_r9_ip_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ipUpdate |-> $stable(ip));

  a_r5_trunc16: assert property (@(posedge clk) disable iff (!rstN)
    (ipUpdate && $past(opSize) == 2'd0) |-> (ip[IP_W-1:16] == '0));

  a_r6_within_limit: assert property (@(posedge clk) disable iff (!rstN)
    (ipUpdate && !$past(longMode)) |->
      (ip <= {{(IP_W-LIM_W){1'b0}}, $past(csLimit)}));

  a_r7_canonical: assert property (@(posedge clk) disable iff (!rstN)
    (ipUpdate && $past(longMode)) |->
      ((&ip[IP_W-1:VA_BITS-1]) || (~|ip[IP_W-1:VA_BITS-1])));

  a_r8_narrow_long: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqValid) && $past(longMode) && $past(opSize) != 2'd2) |->
      (faultStrobe && faultCode == 2'd2));

endmodule

bind jump_target_unit jtu_chk #(
  .IP_W   (IP_W),
  .VA_BITS(VA_BITS),
  .LIM_W  (LIM_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .opSize     (opSize),
  .longMode   (longMode),
  .csLimit    (csLimit),
  .ip         (ip),
  .ipUpdate   (ipUpdate),
  .faultStrobe(faultStrobe),
  .faultCode  (faultCode)
);

// File: tb/jump_target_unit_tb.sv
`timescale 1ns/1ps
module jump_target_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] nextIp = '0;
  logic        isRelative = 1'b0;
  logic [1:0]  dispSize = '0;
  logic [31:0] disp = '0;
  logic [63:0] absTarget = '0;
  logic [1:0]  opSize = '0;
  logic        longMode = 1'b0;
  logic [31:0] csLimit = '0;
  logic [63:0] ip;
  logic        ipUpdate;
  logic        faultStrobe;
  logic [1:0]  faultCode;

  int checks = 0;
  int errors = 0;
  logic [63:0] expIp = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  jump_target_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .nextIp(nextIp),
    .isRelative(isRelative), .dispSize(dispSize), .disp(disp),
    .absTarget(absTarget), .opSize(opSize), .longMode(longMode),
    .csLimit(csLimit), .ip(ip), .ipUpdate(ipUpdate),
    .faultStrobe(faultStrobe), .faultCode(faultCode)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference behaviour built from the requirements
  function automatic void model(output logic [63:0] tgt, output logic [1:0] code);
    logic [63:0] ext, raw;
    logic        bad, prot;
    case (dispSize)
      2'd0:    ext = {{56{disp[7]}}, disp[7:0]};
      2'd1:    ext = {{48{disp[15]}}, disp[15:0]};
      default: ext = {{32{disp[31]}}, disp};
    endcase
    raw = isRelative ? nextIp + ext : absTarget;
    if (opSize == 2'd0)      tgt = {48'd0, raw[15:0]};
    else if (opSize == 2'd1) tgt = {32'd0, raw[31:0]};
    else                     tgt = raw;
    bad = isRelative && dispSize == 2'd3;
    if (longMode) bad = bad || opSize != 2'd2 || (isRelative && dispSize == 2'd1);
    else          bad = bad || opSize[1];
    if (longMode) prot = !((&tgt[63:47]) || (~|tgt[63:47]));
    else          prot = tgt > {32'd0, csLimit};
    code = bad ? 2'd2 : (prot ? 2'd1 : 2'd0);
  endfunction

  task automatic run_req(input string req);
    logic [63:0] tgt;
    logic [1:0]  code;
    model(tgt, code);
    if (code == 2'd0) expIp = tgt;
    @(negedge clk);
    reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    check({req, " ip"}, ip, expIp);
    check({req, " update R2"}, {63'd0, ipUpdate}, {63'd0, code == 2'd0});
    check({req, " fault R2"}, {63'd0, faultStrobe}, {63'd0, code != 2'd0});
    check({req, " code"}, {62'd0, faultCode}, {62'd0, code});
    @(posedge clk); #1;
    check({req, " pulse ends R2"}, {62'd0, ipUpdate, faultStrobe}, 64'd0);
    check({req, " ip held R9"}, ip, expIp);
  endtask

  task automatic setup(input logic lm, input logic [1:0] os, input logic rel,
                       input logic [1:0] ds, input logic [31:0] d,
                       input logic [63:0] nip, input logic [63:0] abs_t,
                       input logic [31:0] lim);
    @(negedge clk);
    longMode = lm; opSize = os; isRelative = rel; dispSize = ds; disp = d;
    nextIp = nip; absTarget = abs_t; csLimit = lim;
  endtask

  task automatic t_reset;
    check("R1 ip", ip, 64'd0);
    check("R1 strobes", {61'd0, ipUpdate, faultStrobe, |faultCode}, 64'd0);
  endtask

  task automatic t_rel_legacy;
    setup(0, 2'd1, 1, 2'd0, 32'h0000_00FE, 64'h1000, '0, 32'hFFFF);
    run_req("R3 rel8 negative");
    setup(0, 2'd0, 1, 2'd1, 32'h0000_0020, 64'hFFF0, '0, 32'hFFFF);
    run_req("R5 rel16 wrap16");
    setup(0, 2'd1, 1, 2'd2, 32'h8000_0010, 64'h8000_0000, '0, 32'hFFFF_FFFF);
    run_req("R5 rel32 wrap32");
  endtask

  task automatic t_abs;
    setup(0, 2'd1, 0, 2'd3, 32'h0, 64'h0, 64'hDEAD_BEEF_0000_1234, 32'hFFFF_FFFF);
    run_req("R4 abs32 dispSize ignored");
    setup(0, 2'd0, 0, 2'd0, 32'h0, 64'h0, 64'h1234_5678, 32'hFFFF);
    run_req("R4 abs16");
  endtask

  task automatic t_limit;
    setup(0, 2'd1, 1, 2'd2, 32'h100, 64'h2000, '0, 32'h20FF);
    run_req("R6 beyond limit");
    setup(0, 2'd1, 1, 2'd2, 32'h0FF, 64'h2000, '0, 32'h20FF);
    run_req("R6 at limit");
  endtask

  task automatic t_long;
    setup(1, 2'd2, 1, 2'd2, 32'hFFFF_FF00, 64'h0000_7FFF_FFFF_0010, '0, 32'h0);
    run_req("R7 rel32 limit ignored");
    setup(1, 2'd2, 1, 2'd2, 32'h20, 64'h0000_7FFF_FFFF_FFF0, '0, 32'h0);
    run_req("R7 rel crosses noncanonical");
    setup(1, 2'd2, 0, 2'd0, 32'h0, 64'h0, 64'hFFFF_8000_0000_0000, 32'h0);
    run_req("R7 abs high canonical");
    setup(1, 2'd2, 0, 2'd0, 32'h0, 64'h0, 64'h0001_0000_0000_0000, 32'h0);
    run_req("R7 abs noncanonical");
  endtask

  task automatic t_bad_form;
    setup(1, 2'd1, 0, 2'd0, 32'h0, 64'h0, 64'h40, 32'h0);
    run_req("R8 long abs32");
    setup(1, 2'd2, 1, 2'd1, 32'h10, 64'h0001_0000_0000_0000, '0, 32'h0);
    run_req("R8 long rel16 over GP");
    setup(0, 2'd2, 1, 2'd0, 32'h4, 64'h100, '0, 32'h0);
    run_req("R8 legacy op64 over GP");
    setup(0, 2'd1, 1, 2'd3, 32'h4, 64'h100, '0, 32'hFFFF);
    run_req("R8 reserved disp size");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_rel_legacy();
    t_abs();
    t_limit();
    t_long();
    t_bad_form();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule